// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives an 8-bit NAND flash bus from a small register set. Software loads the opcode for the first command and the opcode for the second command, a 64-bit address image split across two words, and a 32-bit data word. It then writes a control word with its top bit set. That control word decides which bus phases run and how many bytes each phase moves. The sequencer plays those phases out with timed write and read strobes and holds the chip enable low for the whole sequence. If a second command is issued, the sequencer then waits for the device's ready/busy line to drop and rise again. When the sequence ends, the GO bit clears. Received bytes are merged into the data word, which software reads back at the same address.

A typical page read is command, five address cycles, second command, busy wait. A page program is command, address, data, second command, busy wait. A reset needs only a single command byte. Each of these is one control word plus its operand registers.

Top module: `nand_cmd_engine`

## Requirements
- R1: After reset, status reads 0 (GO clear, timeout flag clear). CLE and ALE are low, and CE#, WE# and RE# are high.
- R2: Enabled phases run in this order: first command (control bit 30), address (bit 29), data (bit 28 together with bit 27 or bit 26), then the second command (bit 25). When bit 24 is clear, the second command comes before the data phase instead of after it.
- R3: The address phase issues (control bits 2:0) + 1 cycles with ALE high. Cycle k drives byte k of {address-high word, address-low word}, least significant byte first.
- R4: A transmit data phase (bit 27 set, bit 26 clear) issues (control bits 21:20) + 1 WE# strobes. Strobe k drives bits 8k+7:8k of the data word, with CLE and ALE low.
- R5: A receive data phase (bit 26) issues (bits 21:20) + 1 RE# strobes. The byte read on strobe k is stored in bits 8k+7:8k of the data word, and the other bytes keep their value.
- R6: A control word with only the first-command bit set (plus GO and CE bit 8) issues exactly one byte with CLE high and then completes.
- R7: GO (status bit 31) reads 1 from the cycle after an accepted start until the sequence ends, and then clears by itself.
- R8: After the second command, GO stays set until R/B# has gone low and then returned high.
- R9: If the busy wait lasts longer than the wait-limit register (in cycles), the sequence ends: GO clears and status bit 0 reads 1. Status bit 0 clears on the next accepted start.
- R10: Each WE# or RE# strobe is low for exactly T_LOW clock cycles. WE# and RE# are never low together. CLE, ALE and the I/O lines stay stable while a strobe is low.
- R11: While GO is set, register writes are ignored. A new control word does not start a sequence, and the operand registers keep their values.
- R12: When control bit 8 is set, CE# is low on every strobe of the sequence and high again once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1 first opcode, 2 second opcode, 3 address low, 4 address high, 5 data, 6 status, 7 wait limit |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O byte driven to the device |
| nand_io_oe | output | 1 | I/O output enable |
| nand_io_in | input | 8 | I/O byte from the device |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
A phase state that is wrong shows up at the rising edge of the first WE# strobe as a byte with the wrong CLE/ALE tag or the wrong value, a few cycles after the start. A skipped or repeated phase changes the number of latched bytes before GO clears. A byte counter that is off by one puts the wrong address byte or data byte on the bus, or sends a received byte to the wrong lane of the data word. A fault in the busy-wait logic shows as GO clearing before R/B# has risen, or as a wrong timeout flag once the wait limit has passed.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   // control word fields
   localparam int CB_GO    = 31;
   localparam int CB_CLE   = 30;
   localparam int CB_ALE   = 29;
   localparam int CB_PIO   = 28;
   localparam int CB_TX    = 27;
   localparam int CB_RX    = 26;
   localparam int CB_SEC   = 25;
   localparam int CB_LATE  = 24;
   localparam int CB_CE0   = 8;
   localparam int CB_NB_LO = 20;
   localparam int NB_W     = 2;
   localparam int NA_W     = 3;

   // register indices
   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_OP1   = 3'd1;
   localparam logic [2:0] RA_OP2   = 3'd2;
   localparam logic [2:0] RA_ALO   = 3'd3;
   localparam logic [2:0] RA_AHI   = 3'd4;
   localparam logic [2:0] RA_DATA  = 3'd5;
   localparam logic [2:0] RA_STAT  = 3'd6;
   localparam logic [2:0] RA_LIMIT = 3'd7;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD1, ST_ADDR, ST_CMD2, ST_DATA, ST_WLO, ST_WHI, ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic            cle;
      logic            ale;
      logic            dat;
      logic            rx;
      logic            sec;
      logic            late;
      logic            ce0;
      logic [NA_W-1:0] naddr;
      logic [NB_W-1:0] nbyte;
   } seq_cmd_t;

   function automatic seq_cmd_t decode_ctrl(input logic [31:0] w);
      seq_cmd_t c;
      c.cle   = w[CB_CLE];
      c.ale   = w[CB_ALE];
      c.dat   = w[CB_PIO] & (w[CB_TX] | w[CB_RX]);
      c.rx    = w[CB_RX];
      c.sec   = w[CB_SEC];
      c.late  = w[CB_LATE];
      c.ce0   = w[CB_CE0];
      c.naddr = w[NA_W-1:0];
      c.nbyte = w[CB_NB_LO +: NB_W];
      return c;
   endfunction

   // first enabled phase strictly after position 'from'
   // 0 start, 1 cmd1, 2 addr, 3 early cmd2, 4 data, 5 late cmd2
   function automatic seq_state_e next_phase(input logic [2:0] from, input seq_cmd_t c);
      if (from < 3'd1 && c.cle)              return ST_CMD1;
      if (from < 3'd2 && c.ale)              return ST_ADDR;
      if (from < 3'd3 && c.sec && !c.late)   return ST_CMD2;
      if (from < 3'd4 && c.dat)              return ST_DATA;
      if (from < 3'd5 && c.sec && c.late)    return ST_CMD2;
      return ST_DONE;
   endfunction

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
   import nand_seq_pkg::*;
#(
   parameter int LIMIT_W   = 16,
   parameter int LIMIT_RST = 500
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [2:0]         addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   input  logic               busy,
   input  logic               tmo,
   input  logic               rx_we,
   input  logic [NB_W-1:0]    rx_idx,
   input  logic [7:0]         rx_byte,
   output logic               start,
   output seq_cmd_t           cmd,
   output logic [7:0]         op1,
   output logic [7:0]         op2,
   output logic [63:0]        addr_img,
   output logic [31:0]        data,
   output logic [LIMIT_W-1:0] limit
);

   localparam logic [LIMIT_W-1:0] LIMIT_INIT = LIMIT_W'(LIMIT_RST);

   logic [31:0] ctrl_q, alo_q, ahi_q, data_q;
   logic [7:0]  op1_q, op2_q;
   logic [LIMIT_W-1:0] limit_q;
   logic        wr_ok;

   assign wr_ok = wr && !busy;
   assign start = wr_ok && (addr == RA_CTRL) && wdata[CB_GO];
   assign cmd   = decode_ctrl(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         op1_q   <= '0;
         op2_q   <= '0;
         alo_q   <= '0;
         ahi_q   <= '0;
         data_q  <= '0;
         limit_q <= LIMIT_INIT;
      end else if (wr_ok) begin
         case (addr)
            RA_CTRL:  ctrl_q  <= wdata;
            RA_OP1:   op1_q   <= wdata[7:0];
            RA_OP2:   op2_q   <= wdata[7:0];
            RA_ALO:   alo_q   <= wdata;
            RA_AHI:   ahi_q   <= wdata;
            RA_DATA:  data_q  <= wdata;
            RA_LIMIT: limit_q <= wdata[LIMIT_W-1:0];
            default:  ;
         endcase
      end else if (rx_we) begin
         data_q[{rx_idx, 3'b000} +: 8] <= rx_byte;
      end
   end

   always_comb begin
      case (addr)
         RA_CTRL:  rdata = {busy, ctrl_q[30:0]};
         RA_OP1:   rdata = {24'd0, op1_q};
         RA_OP2:   rdata = {24'd0, op2_q};
         RA_ALO:   rdata = alo_q;
         RA_AHI:   rdata = ahi_q;
         RA_DATA:  rdata = data_q;
         RA_STAT:  rdata = {busy, 30'd0, tmo};
         default:  rdata = 32'(limit_q);
      endcase
   end

   assign op1      = op1_q;
   assign op2      = op2_q;
   assign addr_img = {ahi_q, alo_q};
   assign data     = data_q;
   assign limit    = limit_q;

   // R11
   wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr) |=> ($stable(op1_q) && $stable(op2_q) && $stable(alo_q)
                        && $stable(ahi_q) && $stable(limit_q)));

endmodule

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe #(
   parameter int T_LOW  = 2,
   parameter int T_HIGH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd,
   output logic busy,
   output logic sample,
   output logic done,
   output logic we_n,
   output logic re_n
);

   localparam int CNT_MAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(T_LOW - 1);
   localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(T_HIGH - 1);

   generate
      if (T_LOW < 1) begin : g_bad_low
         $error("strobe low time must be at least one cycle");
      end
      if (T_HIGH < 1) begin : g_bad_high
         $error("strobe high time must be at least one cycle");
      end
   endgenerate

   logic             act_q, low_q, rd_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         low_q <= 1'b0;
         rd_q  <= 1'b0;
         cnt_q <= '0;
      end else if (!act_q) begin
         if (start) begin
            act_q <= 1'b1;
            low_q <= 1'b1;
            rd_q  <= rd;
            cnt_q <= '0;
         end
      end else if (low_q) begin
         if (cnt_q == LOW_END) begin
            low_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         if (cnt_q == HIGH_END) begin
            act_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy   = act_q;
   assign sample = act_q && low_q && (cnt_q == LOW_END);
   assign done   = act_q && !low_q && (cnt_q == HIGH_END);
   assign we_n   = !(act_q && low_q && !rd_q);
   assign re_n   = !(act_q && low_q && rd_q);

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_n || re_n));

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
   import nand_seq_pkg::*;
#(
   parameter int LIMIT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  seq_cmd_t           cmd,
   input  logic [7:0]         op1,
   input  logic [7:0]         op2,
   input  logic [63:0]        addr_img,
   input  logic [31:0]        data,
   input  logic [LIMIT_W-1:0] limit,
   input  logic               rb_s,
   input  logic               stb_busy,
   input  logic               stb_sample,
   input  logic               stb_done,
   output logic               stb_start,
   output logic               stb_rd,
   output logic               go,
   output logic               tmo,
   output logic               cle,
   output logic               ale,
   output logic               ce_n,
   output logic [7:0]         io_out,
   output logic               io_oe,
   output logic               rx_we,
   output logic [NB_W-1:0]    rx_idx
);

   seq_state_e         st_q;
   seq_cmd_t           c_q;
   logic [NA_W-1:0]    byte_q;
   logic [LIMIT_W-1:0] wcnt_q;
   logic               go_q, tmo_q;
   logic               in_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         c_q    <= '0;
         byte_q <= '0;
         wcnt_q <= '0;
         go_q   <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               c_q    <= cmd;
               go_q   <= 1'b1;
               tmo_q  <= 1'b0;
               byte_q <= '0;
               st_q   <= next_phase(3'd0, cmd);
            end
            ST_CMD1: if (stb_done) st_q <= next_phase(3'd1, c_q);
            ST_ADDR: if (stb_done) begin
               if (byte_q == c_q.naddr) begin
                  byte_q <= '0;
                  st_q   <= next_phase(3'd2, c_q);
               end else begin
                  byte_q <= byte_q + 1'b1;
               end
            end
            ST_DATA: if (stb_done) begin
               if (byte_q[NB_W-1:0] == c_q.nbyte) begin
                  byte_q <= '0;
                  st_q   <= next_phase(3'd4, c_q);
               end else begin
                  byte_q <= byte_q + 1'b1;
               end
            end
            ST_CMD2: if (stb_done) begin
               wcnt_q <= '0;
               st_q   <= ST_WLO;
            end
            ST_WLO: begin
               if (!rb_s) begin
                  st_q   <= ST_WHI;
                  wcnt_q <= wcnt_q + 1'b1;
               end else if (wcnt_q == limit) begin
                  tmo_q <= 1'b1;
                  st_q  <= ST_DONE;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            ST_WHI: begin
               if (rb_s) begin
                  st_q <= next_phase(c_q.late ? 3'd5 : 3'd3, c_q);
               end else if (wcnt_q >= limit) begin
                  tmo_q <= 1'b1;
                  st_q  <= ST_DONE;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            default: begin
               go_q <= 1'b0;
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign in_phase  = (st_q == ST_CMD1) || (st_q == ST_ADDR) ||
                      (st_q == ST_DATA) || (st_q == ST_CMD2);
   assign stb_start = in_phase && !stb_busy;
   assign stb_rd    = (st_q == ST_DATA) && c_q.rx;

   always_comb begin
      case (st_q)
         ST_CMD1: io_out = op1;
         ST_CMD2: io_out = op2;
         ST_ADDR: io_out = addr_img[{byte_q, 3'b000} +: 8];
         ST_DATA: io_out = data[{byte_q[NB_W-1:0], 3'b000} +: 8];
         default: io_out = 8'h00;
      endcase
   end

   assign cle    = (st_q == ST_CMD1) || (st_q == ST_CMD2);
   assign ale    = (st_q == ST_ADDR);
   assign io_oe  = in_phase && !stb_rd;
   assign ce_n   = !(go_q && c_q.ce0);
   assign go     = go_q;
   assign tmo    = tmo_q;
   assign rx_we  = stb_sample && stb_rd;
   assign rx_idx = byte_q[NB_W-1:0];

   // R7
   go_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> go_q);

   // R9
   tmo_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_q) |=> !go_q);

   // R2
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cle, ale, stb_rd}));

endmodule

// File: rtl/nand_cmd_engine.sv
module nand_cmd_engine
   import nand_seq_pkg::*;
#(
   parameter int T_LOW       = 2,
   parameter int T_HIGH      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int LIMIT_W     = 16,
   parameter int LIMIT_RST   = 500
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        nand_ce_n,
   output logic        nand_cle,
   output logic        nand_ale,
   output logic        nand_we_n,
   output logic        nand_re_n,
   output logic [7:0]  nand_io_out,
   output logic        nand_io_oe,
   input  logic [7:0]  nand_io_in,
   input  logic        nand_rb_n
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("ready/busy synchronizer needs at least one stage");
      end
      if (LIMIT_W < 2 || LIMIT_W > 32) begin : g_bad_lim
         $error("wait limit width must be 2..32");
      end
   endgenerate

   logic               rb_s;
   logic               start, go, tmo;
   seq_cmd_t           cmd;
   logic [7:0]         op1, op2;
   logic [63:0]        addr_img;
   logic [31:0]        data;
   logic [LIMIT_W-1:0] limit;
   logic               rx_we;
   logic [NB_W-1:0]    rx_idx;
   logic               stb_start, stb_rd, stb_busy, stb_sample, stb_done;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= nand_rb_n;
         end
         assign rb_s = q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[SYNC_STAGES-2:0], nand_rb_n};
         end
         assign rb_s = q[SYNC_STAGES-1];
      end
   endgenerate

   nand_seq_regs #(
      .LIMIT_W   (LIMIT_W),
      .LIMIT_RST (LIMIT_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .busy     (go),
      .tmo      (tmo),
      .rx_we    (rx_we),
      .rx_idx   (rx_idx),
      .rx_byte  (nand_io_in),
      .start    (start),
      .cmd      (cmd),
      .op1      (op1),
      .op2      (op2),
      .addr_img (addr_img),
      .data     (data),
      .limit    (limit)
   );

   nand_seq_fsm #(
      .LIMIT_W (LIMIT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cmd        (cmd),
      .op1        (op1),
      .op2        (op2),
      .addr_img   (addr_img),
      .data       (data),
      .limit      (limit),
      .rb_s       (rb_s),
      .stb_busy   (stb_busy),
      .stb_sample (stb_sample),
      .stb_done   (stb_done),
      .stb_start  (stb_start),
      .stb_rd     (stb_rd),
      .go         (go),
      .tmo        (tmo),
      .cle        (nand_cle),
      .ale        (nand_ale),
      .ce_n       (nand_ce_n),
      .io_out     (nand_io_out),
      .io_oe      (nand_io_oe),
      .rx_we      (rx_we),
      .rx_idx     (rx_idx)
   );

   nand_seq_strobe #(
      .T_LOW  (T_LOW),
      .T_HIGH (T_HIGH)
   ) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (stb_start),
      .rd     (stb_rd),
      .busy   (stb_busy),
      .sample (stb_sample),
      .done   (stb_done),
      .we_n   (nand_we_n),
      .re_n   (nand_re_n)
   );

   // R10
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |->
         ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_io_out)));

   // R12
   ce_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_ce_n |-> go);

endmodule

// File: tb/nand_cmd_engine_tb.sv
module nand_cmd_engine_tb;

   localparam int T_LOW = 2;

   typedef struct packed {
      logic [31:0] ctrl;
      logic [7:0]  op1;
      logic [7:0]  op2;
      logic [31:0] alo;
      logic [31:0] ahi;
      logic [31:0] data;
   } vec_t;

   // read page, program, reset, erase, tx only, status rx, column change rx
   localparam vec_t VECS [7] = '{
      '{32'hE2000104, 8'h00, 8'h30, 32'h12345678, 32'h0000009A, 32'h00000000},
      '{32'hFB300104, 8'h80, 8'h10, 32'h00020800, 32'h00000001, 32'hDDCCBBAA},
      '{32'hC0000100, 8'hFF, 8'h00, 32'h00000000, 32'h00000000, 32'h00000000},
      '{32'hE2000102, 8'h60, 8'hD0, 32'h00ABCDEF, 32'h00000000, 32'h00000000},
      '{32'h98200100, 8'h00, 8'h00, 32'h00000000, 32'h00000000, 32'h00332211},
      '{32'hD4000100, 8'h70, 8'h00, 32'h00000000, 32'h00000000, 32'h55667788},
      '{32'hF6300101, 8'h05, 8'hE0, 32'h00000204, 32'h00000000, 32'h00000000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
   logic [7:0]  nand_io_out;
   logic [7:0]  nand_io_in = 8'h00;
   logic        nand_rb_n = 1'b1;

   always #5 clk = ~clk;

   nand_cmd_engine u_dut (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .nand_ce_n (nand_ce_n),
      .nand_cle (nand_cle), .nand_ale (nand_ale), .nand_we_n (nand_we_n),
      .nand_re_n (nand_re_n), .nand_io_out (nand_io_out), .nand_io_oe (nand_io_oe),
      .nand_io_in (nand_io_in), .nand_rb_n (nand_rb_n)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // device model and bus log: tag 1 cmd, 2 addr, 3 tx data, 0 rx data
   bit         log_en = 0;
   bit         busy_en = 1;
   logic [9:0] log_q [64];
   int         log_n = 0;
   int         rd_idx = 0;
   int         cle_cnt = 0, cle_seen = 0, busy_left = 0;
   int         rb_rises = 0;
   int         wl = 0, rl = 0, wbad = 0, rbad = 0, ce_bad = 0;

   always @(posedge nand_we_n) if (log_en) begin
      if (log_n < 64) log_q[log_n] = {nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd3), nand_io_out};
      log_n++;
      if (nand_cle) begin
         rd_idx = 0;
         cle_cnt++;
      end
   end

   always @(negedge nand_re_n) if (log_en) nand_io_in = 8'hA0 + 8'(rd_idx);

   always @(posedge nand_re_n) if (log_en) begin
      if (log_n < 64) log_q[log_n] = {2'd0, nand_io_in};
      log_n++;
      rd_idx++;
   end

   always @(posedge clk) begin
      if (cle_cnt != cle_seen) begin
         cle_seen = cle_cnt;
         if (busy_en) busy_left = 8;
      end else if (busy_left > 0) begin
         busy_left--;
      end
      nand_rb_n <= (busy_left == 0);
   end

   always @(posedge nand_rb_n) if (log_en) rb_rises++;

   always @(posedge clk) if (log_en) begin
      if (!nand_we_n) wl++;
      else if (wl != 0) begin
         if (wl != T_LOW) wbad++;
         wl = 0;
      end
      if (!nand_re_n) rl++;
      else if (rl != 0) begin
         if (rl != T_LOW) rbad++;
         rl = 0;
      end
      if ((!nand_we_n || !nand_re_n) && nand_ce_n) ce_bad++;
   end

   logic [9:0] exp_q [64];
   int         exp_n;
   logic [31:0] exp_resp;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(output bit ok);
      logic [31:0] s;
      ok = 0;
      for (int i = 0; i < 3000; i++) begin
         rreg(3'd6, s);
         if (!s[31]) begin
            ok = 1;
            break;
         end
      end
   endtask

   // expected bus bytes from R2..R6
   task automatic build_exp(input vec_t v);
      logic [63:0] a;
      int na, nb;
      a = {v.ahi, v.alo};
      na = int'(v.ctrl[2:0]) + 1;
      nb = int'(v.ctrl[21:20]) + 1;
      exp_n = 0;
      exp_resp = v.data;
      if (v.ctrl[30]) begin exp_q[exp_n] = {2'd1, v.op1}; exp_n++; end
      if (v.ctrl[29])
         for (int i = 0; i < na; i++) begin exp_q[exp_n] = {2'd2, a[8*i +: 8]}; exp_n++; end
      if (v.ctrl[25] && !v.ctrl[24]) begin exp_q[exp_n] = {2'd1, v.op2}; exp_n++; end
      if (v.ctrl[28] && (v.ctrl[27] || v.ctrl[26]))
         for (int i = 0; i < nb; i++) begin
            if (v.ctrl[26]) begin
               exp_q[exp_n] = {2'd0, 8'hA0 + 8'(i)};
               exp_resp[8*i +: 8] = 8'hA0 + 8'(i);
            end else begin
               exp_q[exp_n] = {2'd3, v.data[8*i +: 8]};
            end
            exp_n++;
         end
      if (v.ctrl[25] && v.ctrl[24]) begin exp_q[exp_n] = {2'd1, v.op2}; exp_n++; end
   endtask

   task automatic cmp_log(input string req);
      int bad = -1;
      chk(log_n == exp_n, req, "bus byte count", 32'(log_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++)
         if (log_q[i] !== exp_q[i] && bad < 0) bad = i;
      if (bad >= 0) chk(0, req, "bus byte tag/value", 32'(log_q[bad]), 32'(exp_q[bad]));
      else          chk(1, req, "bus byte tag/value", 0, 0);
   endtask

   task automatic load_vec(input vec_t v);
      wreg(3'd1, {24'd0, v.op1});
      wreg(3'd2, {24'd0, v.op2});
      wreg(3'd3, v.alo);
      wreg(3'd4, v.ahi);
      wreg(3'd5, v.data);
      build_exp(v);
      log_n = 0;
      rd_idx = 0;
   endtask

   task automatic run_vec(input vec_t v, input string req);
      bit ok;
      int r0;
      logic [31:0] s, d;
      load_vec(v);
      r0 = rb_rises;
      wreg(3'd0, v.ctrl);
      rreg(3'd6, s);
      chk(s[31] == 1'b1, "R7", "GO after start", s, 32'h80000000);
      wait_idle(ok);
      chk(ok, "R7", "GO self-clear", 32'(ok), 1);
      cmp_log(req);
      rreg(3'd6, s);
      chk(s == 32'd0, "R9", "status after normal end", s, 0);
      if (v.ctrl[25])
         chk(rb_rises > r0 && nand_rb_n, "R8", "GO held until ready", 32'(rb_rises - r0), 1);
      if (v.ctrl[28] && v.ctrl[26]) begin
         rreg(3'd5, d);
         chk(d == exp_resp, "R5", "received data word", d, exp_resp);
      end
      chk(nand_ce_n == 1'b1, "R12", "CE# high after end", 32'(nand_ce_n), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] s, d;
      bit ok;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rreg(3'd6, s);
      chk(s == 32'd0, "R1", "status after reset", s, 0);
      chk({nand_cle, nand_ale} == 2'b00, "R1", "CLE/ALE after reset", {nand_cle, nand_ale}, 0);
      chk({nand_ce_n, nand_we_n, nand_re_n} == 3'b111, "R1", "CE#/WE#/RE# after reset",
          {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
      log_en = 1;

      // vector walk: R2 R3 R4 R5 R6
      for (int i = 0; i < 7; i++) begin
         case (i)
            0, 3:    run_vec(VECS[i], "R3");
            1, 4:    run_vec(VECS[i], "R4");
            2:       run_vec(VECS[i], "R6");
            default: run_vec(VECS[i], "R2");
         endcase
      end

      // R10 strobe widths and R12 chip enable during strobes
      chk(wbad == 0, "R10", "WE# low width mismatches", 32'(wbad), 0);
      chk(rbad == 0, "R10", "RE# low width mismatches", 32'(rbad), 0);
      chk(ce_bad == 0, "R12", "strobes with CE# high", 32'(ce_bad), 0);

      // R11 writes while busy are ignored
      load_vec(VECS[0]);
      wreg(3'd0, VECS[0].ctrl);
      repeat (5) @(negedge clk);
      wreg(3'd0, 32'hC0000100);
      wreg(3'd1, 32'h000000FF);
      wait_idle(ok);
      repeat (60) @(negedge clk);
      cmp_log("R11");
      rreg(3'd1, d);
      chk(d == 32'h00000000, "R11", "first opcode kept", d, 0);

      // R9 busy wait timeout
      busy_en = 0;
      wreg(3'd7, 32'd20);
      load_vec(VECS[0]);
      wreg(3'd0, VECS[0].ctrl);
      wait_idle(ok);
      chk(ok, "R9", "GO clears on timeout", 32'(ok), 1);
      rreg(3'd6, s);
      chk(s == 32'd1, "R9", "timeout flag set", s, 1);
      busy_en = 1;
      wreg(3'd7, 32'd500);
      run_vec(VECS[2], "R6");
      rreg(3'd6, s);
      chk(s[0] == 1'b0, "R9", "timeout flag cleared by new start", s, 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule